// File: doc/BRIEF.md
# Polarity-Configurable Interrupt Aggregator

The block takes a vector of external interrupt request lines, up to 64 of them, and presents each line to an upstream interrupt controller as an active-high level request. Every input is first brought into the local clock domain through two flip-flops. Its sense is then corrected by a per-line polarity bit, so that active-low levels and falling edges look like active-high levels and rising edges. Finally the line passes through a per-line mask.

Each line can be set to level pass-through or to edge-latched operation. In edge-latched operation, a rising transition of the corrected signal moves the line's small state machine from `LN_IDLE` to `LN_HELD`. The line then drives a steady request until software clears it. Software clears the state machine with a one-bit end-of-interrupt write, which is the transition `LN_HELD -> LN_IDLE`. A new edge arriving in the same cycle as that clear wins, so the line stays in `LN_HELD`. Clearing the line's mode bit also forces `LN_HELD -> LN_IDLE`.

A build parameter removes end-of-interrupt handling. In that build the held state is released instead when software unmasks a line that was masked. Software reaches the block over a simple write-strobe register bus of 16-bit registers with combinational read data. Each register covers a group of 16 lines.

Top module: `irq_polarity_aggr`

## Requirements
- R1: After reset every mask bit reads 1, every polarity and mode bit reads 0, no line is held and every bit of `irq_out` is 0.
- R2: Line n is controlled by bit n%16 of the register at byte address bank_base + 4*(n/16). The bank bases are mask 0x00, polarity 0x10, end-of-interrupt 0x20 and mode 0x30. Any address with bits [1:0] not zero, or with any bit at position 6 or above set, reads 0 and ignores writes.
- R3: A change on `irq_in` reaches the level path after exactly two rising clock edges.
- R4: A polarity bit of 1 inverts its line, so a low input counts as active. A polarity bit of 0 passes the input unchanged.
- R5: When a line's mode bit is 0, its output equals the polarity-corrected synchronised input ANDed with NOT mask.
- R6: When a line's mode bit is 1, a 0-to-1 transition of the corrected signal sets the line's held state one edge after the transition reaches the level path. The output stays 1 after the input returns to idle.
- R7: In the end-of-interrupt build, writing 1 to a bit of the 0x20 bank clears that line's held state. Bits written as 0 change nothing. The 0x20 bank always reads 0.
- R8: If a new edge and a clear for the same line land on the same clock edge, the line stays held.
- R9: A masked line always outputs 0. In the end-of-interrupt build, an edge that arrives while the line is masked is still held and appears when the line is unmasked.
- R10: The mask, polarity and mode registers read back every one of their 16 bits exactly as written. This lets software save and restore them around a power-down.
- R11: In the build without end-of-interrupt handling, writes to the 0x20 bank have no effect. A held line is released when a write to the mask bank changes its mask bit from 1 to 0.
- R12: Writing a line's mode bit to 0 releases its held state on the next edge, so setting the mode back to 1 does not bring back an old request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | NUM_LINES | Raw interrupt request lines, asynchronous |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq_out | output | NUM_LINES | Active-high level requests to the upstream controller |

## Verification
The bench targets the collision of a new edge with an end-of-interrupt write on the same edge. A design that lets the clear win there would silently drop an interrupt. It also measures the exact two-edge input delay, so an extra or missing synchroniser stage shows up as a one-cycle shift against the reference model. Three further cases are checked:
- Edges captured while a line is masked must survive, or they are lost on unmask.
- Switching a line back to edge mode must not revive a stale request.
- The build without end-of-interrupt handling must ignore the 0x20 bank and release a line only on unmask; otherwise either the line never releases or releases at the wrong time.

// File: rtl/irq_aggr_pkg.sv
package irq_aggr_pkg;

    localparam int REG_W = 16;

    typedef enum logic [1:0] {
        BANK_MASK = 2'd0,
        BANK_POL  = 2'd1,
        BANK_EOI  = 2'd2,
        BANK_MODE = 2'd3
    } bank_e;

    typedef enum logic {
        LN_IDLE = 1'b0,
        LN_HELD = 1'b1
    } line_state_e;

endpackage

// File: rtl/irq_aggr_sync.sv
module irq_aggr_sync #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d;
            stage2_q <= stage1_q;
        end
    end

    assign q = stage2_q;

endmodule

// File: rtl/irq_aggr_regs.sv
module irq_aggr_regs
    import irq_aggr_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int ADDR_W    = 8,
    parameter bit HAS_EOI   = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [REG_W-1:0]     bus_wdata,
    output logic [REG_W-1:0]     bus_rdata,
    output logic [NUM_LINES-1:0] mask_q,
    output logic [NUM_LINES-1:0] pol_q,
    output logic [NUM_LINES-1:0] mode_q,
    output logic [NUM_LINES-1:0] clr_hit
);

    localparam int GROUPS = (NUM_LINES + REG_W - 1) / REG_W;
    localparam int PAD_W  = GROUPS * REG_W;

    logic [PAD_W-1:0] mask_r;
    logic [PAD_W-1:0] pol_r;
    logic [PAD_W-1:0] mode_r;
    logic [PAD_W-1:0] clr_w;

    logic       addr_ok;
    logic [1:0] grp;
    bank_e      bank;

    assign grp     = bus_addr[3:2];
    assign bank    = bank_e'(bus_addr[5:4]);
    assign addr_ok = (bus_addr[ADDR_W-1:6] == '0) && (bus_addr[1:0] == 2'b00)
                     && ({1'b0, grp} < 3'(GROUPS));

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        logic sel;
        assign sel = bus_wr && addr_ok && (grp == 2'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask_r[g*REG_W +: REG_W] <= '1;
                pol_r[g*REG_W +: REG_W]  <= '0;
                mode_r[g*REG_W +: REG_W] <= '0;
            end else if (sel) begin
                unique case (bank)
                    BANK_MASK: mask_r[g*REG_W +: REG_W] <= bus_wdata;
                    BANK_POL:  pol_r[g*REG_W +: REG_W]  <= bus_wdata;
                    BANK_MODE: mode_r[g*REG_W +: REG_W] <= bus_wdata;
                    BANK_EOI:  ;
                endcase
            end
        end

        // Release strobe: end-of-interrupt bits, or 1->0 mask transitions
        assign clr_w[g*REG_W +: REG_W] =
            HAS_EOI ? ((sel && bank == BANK_EOI)  ? bus_wdata : '0)
                    : ((sel && bank == BANK_MASK) ? (mask_r[g*REG_W +: REG_W] & ~bus_wdata) : '0);
    end

    always_comb begin
        bus_rdata = '0;
        if (addr_ok) begin
            for (int g = 0; g < GROUPS; g++) begin
                if (grp == 2'(g)) begin
                    unique case (bank)
                        BANK_MASK: bus_rdata = mask_r[g*REG_W +: REG_W];
                        BANK_POL:  bus_rdata = pol_r[g*REG_W +: REG_W];
                        BANK_MODE: bus_rdata = mode_r[g*REG_W +: REG_W];
                        BANK_EOI:  bus_rdata = '0;
                    endcase
                end
            end
        end
    end

    assign mask_q  = mask_r[NUM_LINES-1:0];
    assign pol_q   = pol_r[NUM_LINES-1:0];
    assign mode_q  = mode_r[NUM_LINES-1:0];
    assign clr_hit = clr_w[NUM_LINES-1:0];

endmodule

// File: rtl/irq_aggr_line.sv
module irq_aggr_line
    import irq_aggr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic rise,
    input  logic clr,
    input  logic edge_mode,
    input  logic masked,
    output logic req_out,
    output logic held
);

    line_state_e state_q;
    line_state_e state_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LN_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            LN_IDLE: begin
                if (edge_mode && rise) begin
                    state_n = LN_HELD;
                end
            end
            LN_HELD: begin
                if (!edge_mode) begin
                    state_n = LN_IDLE;
                end else if (clr && !rise) begin
                    state_n = LN_IDLE;
                end
            end
        endcase
    end

    always_comb begin
        held    = (state_q == LN_HELD);
        req_out = (edge_mode ? held : level) & ~masked;
    end

endmodule

// File: rtl/irq_polarity_aggr.sv
module irq_polarity_aggr
    import irq_aggr_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int ADDR_W    = 8,
    parameter bit HAS_EOI   = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [REG_W-1:0]     bus_wdata,
    output logic [REG_W-1:0]     bus_rdata,
    output logic [NUM_LINES-1:0] irq_out
);

    logic [NUM_LINES-1:0] mask_q;
    logic [NUM_LINES-1:0] pol_q;
    logic [NUM_LINES-1:0] mode_q;
    logic [NUM_LINES-1:0] clr_v;
    logic [NUM_LINES-1:0] sync_q;
    logic [NUM_LINES-1:0] corr;
    logic [NUM_LINES-1:0] corr_d;
    logic [NUM_LINES-1:0] rise_v;
    logic [NUM_LINES-1:0] latch_q;

    irq_aggr_regs #(
        .NUM_LINES (NUM_LINES),
        .ADDR_W    (ADDR_W),
        .HAS_EOI   (HAS_EOI)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .mask_q    (mask_q),
        .pol_q     (pol_q),
        .mode_q    (mode_q),
        .clr_hit   (clr_v)
    );

    irq_aggr_sync #(
        .W (NUM_LINES)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (irq_in),
        .q     (sync_q)
    );

    assign corr = sync_q ^ pol_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            corr_d <= '0;
        end else begin
            corr_d <= corr;
        end
    end

    assign rise_v = corr & ~corr_d;

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
        irq_aggr_line line_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .level     (corr[n]),
            .rise      (rise_v[n]),
            .clr       (clr_v[n]),
            .edge_mode (mode_q[n]),
            .masked    (mask_q[n]),
            .req_out   (irq_out[n]),
            .held      (latch_q[n])
        );
    end

endmodule

// File: rtl/irq_aggr_chk.sv
module irq_aggr_chk #(
    parameter int NUM_LINES = 64,
    parameter int ADDR_W    = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [15:0]          bus_rdata,
    input logic [NUM_LINES-1:0] irq_out,
    input logic [NUM_LINES-1:0] mask_q,
    input logic [NUM_LINES-1:0] mode_q,
    input logic [NUM_LINES-1:0] latch_q,
    input logic [NUM_LINES-1:0] rise_v,
    input logic [NUM_LINES-1:0] clr_v
);

    assert_masked_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out & mask_q) == '0);

    assert_held_persists_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_q & $past(latch_q & mode_q & ~clr_v)) == $past(latch_q & mode_q & ~clr_v));

    assert_edge_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((rise_v & clr_v & mode_q) != '0) |=>
        ((latch_q & $past(rise_v & clr_v & mode_q)) == $past(rise_v & clr_v & mode_q)));

    assert_level_mode_drops_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_q & ~$past(mode_q)) == '0);

    assert_eoi_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_addr[ADDR_W-1:6] == '0) && (bus_addr[5:4] == 2'b10)) |-> (bus_rdata == 16'h0000));

endmodule

bind irq_polarity_aggr irq_aggr_chk #(
    .NUM_LINES (NUM_LINES),
    .ADDR_W    (ADDR_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out),
    .mask_q    (mask_q),
    .mode_q    (mode_q),
    .latch_q   (latch_q),
    .rise_v    (rise_v),
    .clr_v     (clr_v)
);

// File: tb/irq_polarity_aggr_tb_top.sv
module irq_polarity_aggr_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] irq_in = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [15:0] rdata_ne;
    logic [63:0] irq_out;
    logic [63:0] out_ne;

    int checks = 0;
    int errors = 0;
    bit cmp_en = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_polarity_aggr #(.NUM_LINES(64), .ADDR_W(8), .HAS_EOI(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out)
    );

    irq_polarity_aggr #(.NUM_LINES(64), .ADDR_W(8), .HAS_EOI(1'b0)) dut_ne_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_ne),
        .irq_out(out_ne)
    );

    // Behavioural reference for the end-of-interrupt build
    logic [63:0] m_s1, m_s2, m_prev, m_mask, m_pol, m_mode, m_latch;
    logic [63:0] t_corr, t_rise, t_clr, t_wv, t_bm, m_exp;
    int t_grp;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_mask <= '1;
            m_pol <= '0; m_mode <= '0; m_latch <= '0;
        end else begin
            t_corr = m_s2 ^ m_pol;
            t_rise = t_corr & ~m_prev;
            t_clr  = '0;
            if (bus_wr && bus_addr[1:0] == 2'b00 && bus_addr[7:6] == 2'b00) begin
                t_grp = int'(bus_addr[3:2]);
                t_wv  = 64'(bus_wdata) << (t_grp * 16);
                t_bm  = 64'hFFFF << (t_grp * 16);
                case (bus_addr[5:4])
                    2'd0: m_mask <= (m_mask & ~t_bm) | t_wv;
                    2'd1: m_pol  <= (m_pol  & ~t_bm) | t_wv;
                    2'd2: t_clr  = t_wv;
                    default: m_mode <= (m_mode & ~t_bm) | t_wv;
                endcase
            end
            m_latch <= m_mode & (t_rise | (m_latch & ~t_clr));
            m_prev  <= t_corr;
            m_s2    <= m_s1;
            m_s1    <= irq_in;
        end
    end

    assign m_exp = ((m_mode & m_latch) | (~m_mode & (m_s2 ^ m_pol))) & ~m_mask;

    always @(negedge clk) begin
        if (rst_n && cmp_en) begin
            checks++;
            if (irq_out !== m_exp) begin
                errors++;
                $display("FAIL R5/R6 cycle model: irq_out=%h expected=%h", irq_out, m_exp);
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #2 d = bus_rdata;
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic [15:0] lf;
        cyc(3);
        chk("R1 outputs in reset", irq_out, 64'h0);
        rst_n = 1'b1;
        cyc(2);
        cmp_en = 1'b1;
        chk("R1 outputs after reset", irq_out, 64'h0);
        rd(8'h00, d); chk("R1 mask reset", 64'(d), 64'hFFFF);
        rd(8'h0C, d); chk("R1 mask reset grp3", 64'(d), 64'hFFFF);
        rd(8'h10, d); chk("R1 polarity reset", 64'(d), 64'h0);
        rd(8'h30, d); chk("R1 mode reset", 64'(d), 64'h0);

        // R10 / R2 full readback and addressing
        wr(8'h14, 16'hA5C3);
        rd(8'h14, d); chk("R10 polarity readback", 64'(d), 64'hA5C3);
        rd(8'h10, d); chk("R2 other group untouched", 64'(d), 64'h0);
        wr(8'h14, 16'h0000);
        wr(8'h38, 16'h5A3C);
        rd(8'h38, d); chk("R10 mode readback", 64'(d), 64'h5A3C);
        wr(8'h38, 16'h0000);
        wr(8'h40, 16'h0000);
        wr(8'h02, 16'h0000);
        rd(8'h00, d); chk("R2 bad address write ignored", 64'(d), 64'hFFFF);
        rd(8'h40, d); chk("R2 unmapped reads zero", 64'(d), 64'h0);

        // R3 / R5 level path, lines 3 and 20
        wr(8'h00, 16'hFFF7);
        wr(8'h04, 16'hFFEF);
        rd(8'h00, d); chk("R10 mask readback", 64'(d), 64'hFFF7);
        @(negedge clk); irq_in[3] = 1'b1;
        @(negedge clk); chk("R3 one edge not yet", 64'(irq_out[3]), 64'h0);
        @(negedge clk); chk("R3 visible after two edges", 64'(irq_out[3]), 64'h1);
        irq_in[5] = 1'b1;
        cyc(4);
        chk("R9 masked line silent", 64'(irq_out[5]), 64'h0);
        chk("R5 level follows input", 64'(irq_out[3]), 64'h1);
        irq_in[3] = 1'b0; irq_in[5] = 1'b0;
        cyc(3);
        chk("R5 level released", 64'(irq_out[3]), 64'h0);

        // R4 polarity on line 20 (group 1 bit 4)
        wr(8'h14, 16'h0010);
        cyc(2);
        chk("R4 inverted idle low is active", 64'(irq_out[20]), 64'h1);
        @(negedge clk); irq_in[20] = 1'b1;
        cyc(3);
        chk("R4 inverted high is idle", 64'(irq_out[20]), 64'h0);
        wr(8'h14, 16'h0000);
        irq_in[20] = 1'b0;
        cyc(3);

        // R6 / R7 edge latch on line 40 (group 2 bit 8)
        wr(8'h38, 16'h0100);
        wr(8'h08, 16'hFEFF);
        @(negedge clk); irq_in[40] = 1'b1;
        @(negedge clk); irq_in[40] = 1'b0;
        cyc(5);
        chk("R6 edge held after pulse", 64'(irq_out[40]), 64'h1);
        wr(8'h28, 16'h0000);
        chk("R7 zero bits keep held", 64'(irq_out[40]), 64'h1);
        rd(8'h28, d); chk("R7 eoi bank reads zero", 64'(d), 64'h0);
        wr(8'h28, 16'h0100);
        chk("R7 eoi clears held", 64'(irq_out[40]), 64'h0);

        // R8 edge and clear on the same edge
        @(negedge clk); irq_in[40] = 1'b1;
        @(negedge clk);
        @(negedge clk); bus_wr = 1'b1; bus_addr = 8'h28; bus_wdata = 16'h0100;
        @(negedge clk); bus_wr = 1'b0;
        chk("R8 new edge wins over clear", 64'(irq_out[40]), 64'h1);
        irq_in[40] = 1'b0;
        wr(8'h28, 16'h0100);
        chk("R8 later clear works", 64'(irq_out[40]), 64'h0);

        // R9 edge captured while masked
        wr(8'h08, 16'hFFFF);
        @(negedge clk); irq_in[40] = 1'b1;
        @(negedge clk); irq_in[40] = 1'b0;
        cyc(4);
        chk("R9 masked edge hidden", 64'(irq_out[40]), 64'h0);
        wr(8'h08, 16'hFEFF);
        chk("R9 masked edge kept", 64'(irq_out[40]), 64'h1);

        // R12 mode off drops held state
        wr(8'h38, 16'h0000);
        wr(8'h38, 16'h0100);
        chk("R12 stale request gone", 64'(irq_out[40]), 64'h0);

        // R11 build without end-of-interrupt
        wr(8'h08, 16'hFFFF);
        wr(8'h08, 16'hFEFF);
        chk("R11 start released", 64'(out_ne[40]), 64'h0);
        @(negedge clk); irq_in[40] = 1'b1;
        @(negedge clk); irq_in[40] = 1'b0;
        cyc(4);
        chk("R11 edge held", 64'(out_ne[40]), 64'h1);
        wr(8'h28, 16'h0100);
        chk("R11 eoi write ignored", 64'(out_ne[40]), 64'h1);
        wr(8'h08, 16'hFFFF);
        chk("R11 masked output low", 64'(out_ne[40]), 64'h0);
        wr(8'h08, 16'hFEFF);
        chk("R11 unmask releases", 64'(out_ne[40]), 64'h0);

        // Mixed traffic against the reference model
        wr(8'h00, 16'h0000); wr(8'h04, 16'h00F0); wr(8'h08, 16'h0000); wr(8'h0C, 16'hF000);
        wr(8'h10, 16'h3333); wr(8'h18, 16'h0F0F);
        wr(8'h30, 16'hFF00); wr(8'h34, 16'h5555); wr(8'h3C, 16'hFFFF);
        lf = 16'hACE1;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            irq_in = {lf, ~lf, {lf[7:0], lf[15:8]}, lf ^ 16'h9A6D};
            if (i % 7 == 3) begin
                bus_wr = 1'b1;
                bus_addr = {4'h2, 2'(i % 4), 2'b00};
                bus_wdata = lf ^ 16'h0F0F;
            end else begin
                bus_wr = 1'b0;
            end
        end
        @(negedge clk); bus_wr = 1'b0;
        cyc(4);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule